// File: doc/BRIEF.md
# Flash Controller Register Front End

This block sits between the register bus of a chip and an on-chip flash command engine. It holds a read/write mode register and a read-only status register. It decides whether a command-start strobe may launch the engine, and it raises an interrupt when a command ends. Software configures two mode fields: an interrupt enable and a protection enable. Without the protection enable, erase and write commands cannot run.

A launch makes the block busy until the engine reports that it is done, together with a pass/fail result. The result is recorded in sticky status flags. Reading the status register clears these flags. A protected command issued while protection is active never reaches the engine; the block records it at once as a failed completion. The interrupt line follows the status interrupt flag.

The bus port is a single-cycle strobe interface. `reg_sel` chooses the register: 1 selects the mode register, 0 selects the status register. Read data is combinational from `reg_sel`. A read side effect happens only when `reg_rd` is high.

Top module: `flash_regfront`

## Requirements
- R1: After reset the status register reads 0x0020, the mode register reads 0x0000, and `busy`, `irq` and `cmd_launch` are low.
- R2: A write with `reg_sel`=1 stores all 16 bits of `reg_wdata` into the mode register, and the value reads back unchanged. Reading the mode register changes neither register.
- R3: A launch makes `busy` and status bit 2 high from the next cycle on. They return low in the cycle after `eng_done` is seen while busy.
- R4: While `busy` is high, `cmd_start` is ignored. There is no launch, no flag change and no second completion.
- R5: A start with `cmd_prot`=1 (erase or write) launches only when mode bit 3 is 1. When mode bit 3 is 0 it is rejected without launching, and status bit 1 (fail) is set in the next cycle.
- R6: A start with `cmd_prot`=0 launches in the same cycle, whatever the mode register holds.
- R7: A completion with `eng_ok`=1 sets status bit 0 (pass). A completion with `eng_ok`=0 sets status bit 1 (fail).
- R8: A status read (`reg_rd`=1, `reg_sel`=0) clears status bits 0, 1 and 3 from the next cycle on, while bit 2 is unaffected. Writes to the status register are ignored.
- R9: A completion or a rejection sets status bit 3 only when mode bit 4 is 1. `irq` is the level of status bit 3.
- R10: If a status read and a completion land in the same cycle, the flags set by that completion survive the read.
- R11: The flags accumulate. A later completion never clears a flag that an earlier one set; only a status read does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 1 mode, 0 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (status read clears flags) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| cmd_start | input | 1 | Command start request |
| cmd_prot | input | 1 | Request is an erase or write command |
| eng_done | input | 1 | Engine completion pulse |
| eng_ok | input | 1 | Completion result, 1 = success |
| busy | output | 1 | Command in progress |
| cmd_launch | output | 1 | Start is permitted and passed to the engine |
| irq | output | 1 | Command-complete interrupt level |

## Verification
The assertions take for granted that the engine raises `eng_done` only while the block is busy, as a single-cycle pulse, and never in the cycle of a launch. The bench's stub engine waits two idle cycles after a launch before pulsing `eng_done` once. It sends a completion only for a command that was actually launched. All strobes are driven on the falling edge and dropped one cycle later, so each bus access or start is a single-cycle event.

// File: rtl/flash_rf_pkg.sv
// Package: shared widths, bit positions and reset values for the flash
// controller register front end. Bit positions are fixed by software.
package flash_rf_pkg;
    localparam int REG_W       = 16;
    localparam int ST_PASS     = 0;
    localparam int ST_FAIL     = 1;
    localparam int ST_BUSY     = 2;
    localparam int ST_INT      = 3;
    localparam int ST_FIXED    = 5;
    localparam int MD_PROT_EN  = 3;
    localparam int MD_INT_EN   = 4;
    localparam int NUM_FLAGS   = 3;
    localparam int FL_PASS     = 0;
    localparam int FL_FAIL     = 1;
    localparam int FL_INT      = 2;
endpackage

// File: rtl/frf_mode_reg.sv
// Mode register: a plain read/write word. Two fields are decoded for the
// rest of the block. Assumes wr_en is a single-cycle bus strobe.
module frf_mode_reg #(
    parameter int W       = 16,
    parameter int PROT_B  = 3,
    parameter int INT_B   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_word,
    output logic         prot_en,
    output logic         int_en
);
    logic [W-1:0] mode_q;

    // Capture the written word; reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= '0;
        else if (wr_en) mode_q <= wdata;
    end

    assign mode_word = mode_q;
    assign prot_en   = mode_q[PROT_B];
    assign int_en    = mode_q[INT_B];

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_word == $past(wdata)));
endmodule

// File: rtl/frf_sticky.sv
// Sticky flag cell: set dominates clear, so a same-cycle event survives a
// clearing read. Assumes set and clr are synchronous to clk.
module frf_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until a clear with no coincident set.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/frf_cmd_gate.sv
// Command gate: decides whether a start request launches the engine or is
// rejected by protection. Purely combinational; busy comes from status.
module frf_cmd_gate (
    input  logic start,
    input  logic prot,
    input  logic prot_en,
    input  logic busy,
    output logic launch,
    output logic reject
);
    logic accept;

    // Idle requests are accepted; protected ones also need the enable.
    always_comb begin
        accept = start && !busy;
        launch = accept && (!prot || prot_en);
        reject = accept && prot && !prot_en;
    end
endmodule

// File: rtl/frf_status.sv
// Status register: busy tracking plus pass, fail and interrupt flags held in
// sticky cells. Assumes done pulses only while busy and never with launch.
module frf_status
    import flash_rf_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic         reject,
    input  logic         done,
    input  logic         ok,
    input  logic         rd_clr,
    input  logic         int_en,
    output logic [W-1:0] status_word,
    output logic         busy,
    output logic         irq
);
    logic                 busy_q;
    logic                 finish_ev;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    // Busy rises on a launch and falls on the engine's completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_q <= 1'b0;
        else if (launch)           busy_q <= 1'b1;
        else if (done && busy_q)   busy_q <= 1'b0;
    end

    // Translate completion and rejection events into per-flag set strobes.
    always_comb begin
        finish_ev         = (done && busy_q) || reject;
        flag_set[FL_PASS] = done && busy_q && ok;
        flag_set[FL_FAIL] = (done && busy_q && !ok) || reject;
        flag_set[FL_INT]  = finish_ev && int_en;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        frf_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (rd_clr),
            .q     (flag_q[g])
        );
    end

    // Assemble the status word; bit 5 reads as one, the rest as zero.
    always_comb begin
        status_word           = '0;
        status_word[ST_FIXED] = 1'b1;
        status_word[ST_INT]   = flag_q[FL_INT];
        status_word[ST_BUSY]  = busy_q;
        status_word[ST_FAIL]  = flag_q[FL_FAIL];
        status_word[ST_PASS]  = flag_q[FL_PASS];
    end

    assign busy = busy_q;
    assign irq  = flag_q[FL_INT];

    a_r3_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |=> !busy);
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(int_en));
    a_r7_pass_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy && ok) |=> status_word[ST_PASS]);
endmodule

// File: rtl/flash_regfront.sv
// Top: register front end for a flash controller. Decodes the bus strobes,
// holds the mode word, gates command starts and reports status and irq.
// Assumes single-cycle strobes and an engine that completes only when busy.
module flash_regfront
    import flash_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmd_start,
    input  logic             cmd_prot,
    input  logic             eng_done,
    input  logic             eng_ok,
    output logic             busy,
    output logic             cmd_launch,
    output logic             irq
);
    logic             mode_wr;
    logic             stat_clr;
    logic [REG_W-1:0] mode_word;
    logic [REG_W-1:0] stat_word;
    logic             prot_en;
    logic             int_en;
    logic             reject;

    // Bus decode: only the mode register is writable; status read clears.
    always_comb begin
        mode_wr  = reg_wr && reg_sel;
        stat_clr = reg_rd && !reg_sel;
    end

    frf_mode_reg #(.W(REG_W), .PROT_B(MD_PROT_EN), .INT_B(MD_INT_EN)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mode_wr),
        .wdata     (reg_wdata),
        .mode_word (mode_word),
        .prot_en   (prot_en),
        .int_en    (int_en)
    );

    frf_cmd_gate u_gate (
        .start   (cmd_start),
        .prot    (cmd_prot),
        .prot_en (prot_en),
        .busy    (busy),
        .launch  (cmd_launch),
        .reject  (reject)
    );

    frf_status #(.W(REG_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (cmd_launch),
        .reject      (reject),
        .done        (eng_done),
        .ok          (eng_ok),
        .rd_clr      (stat_clr),
        .int_en      (int_en),
        .status_word (stat_word),
        .busy        (busy),
        .irq         (irq)
    );

    // Read mux: select picks the register, no registered read path.
    always_comb begin
        reg_rdata = reg_sel ? mode_word : stat_word;
    end

    a_r4_busy_blocks_launch: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_launch);
    a_r5_reject_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_prot && !busy && !mode_word[MD_PROT_EN])
        |=> (stat_word[ST_FAIL] && !busy));
    a_r6_free_cmd_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_prot && !busy) |-> cmd_launch);
    a_r11_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[ST_FAIL] && !stat_clr) |=> stat_word[ST_FAIL]);
endmodule

// File: tb/flash_regfront_tb.sv
`timescale 1ns/1ps
module flash_regfront_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_sel, reg_wr, reg_rd;
    logic [15:0] reg_wdata, reg_rdata;
    logic        cmd_start, cmd_prot, eng_done, eng_ok;
    logic        busy, cmd_launch, irq;
    int          vecs = 0;
    int          errs = 0;

    always #4 clk = ~clk;

    flash_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_start(cmd_start), .cmd_prot(cmd_prot), .eng_done(eng_done),
        .eng_ok(eng_ok), .busy(busy), .cmd_launch(cmd_launch), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic sel, output logic [15:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] v);
        @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic start_cmd(input logic prot, output logic launched);
        @(negedge clk); cmd_start = 1'b1; cmd_prot = prot;
        #1 launched = cmd_launch;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    // Stub engine: two idle cycles, then one completion pulse.
    task automatic engine_done(input logic ok);
        repeat (2) @(negedge clk);
        eng_done = 1'b1; eng_ok = ok;
        @(negedge clk); eng_done = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic        l;
        logic [15:0] exp_w;
        rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_wdata = '0; cmd_start = 1'b0; cmd_prot = 1'b0;
        eng_done = 1'b0; eng_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(1'b0, v); chk("R1 status", v, 16'h0020);
        peek(1'b1, v); chk("R1 mode", v, 16'h0000);
        chk("R1 busy/irq/launch", {13'd0, busy, irq, cmd_launch}, 16'h0);

        // R2 mode readback, mode read has no side effect
        wr_reg(1'b1, 16'hA5C3);
        rd_reg(1'b1, v); chk("R2 readback", v, 16'hA5C3);
        peek(1'b1, v); chk("R2 after read", v, 16'hA5C3);
        peek(1'b0, v); chk("R2 status untouched", v, 16'h0020);

        // Sweep: interrupt enable x protection enable x command kind x result
        for (int ie = 0; ie < 2; ie++) begin
            for (int pe = 0; pe < 2; pe++) begin
                for (int pr = 0; pr < 2; pr++) begin
                    for (int ok = 0; ok < 2; ok++) begin
                        logic exp_l;
                        logic e_pass, e_fail;
                        wr_reg(1'b1, 16'h0100 | 16'(ie << 4) | 16'(pe << 3));
                        rd_reg(1'b0, v);
                        peek(1'b0, v); chk("R8 cleared", v, 16'h0020);
                        exp_l = (pr == 0) || (pe == 1);
                        start_cmd(pr[0], l);
                        chk(pr != 0 ? "R5 launch" : "R6 launch", {15'd0, l}, {15'd0, exp_l});
                        chk("R3 busy", {15'd0, busy}, {15'd0, exp_l});
                        if (l) begin
                            peek(1'b0, v);
                            chk("R3 busy bit", {15'd0, v[2]}, 16'd1);
                            engine_done(ok[0]);
                            e_pass = ok[0]; e_fail = !ok[0];
                        end else begin
                            e_pass = 1'b0; e_fail = 1'b1;
                        end
                        exp_w = 16'h0020 | 16'(ie << 3) | 16'(e_fail << 1) | 16'(e_pass);
                        peek(1'b0, v);
                        chk(l ? "R7 result" : "R5 reject", v, exp_w);
                        chk("R3 idle", {15'd0, busy}, 16'd0);
                        chk("R9 irq", {15'd0, irq}, 16'(ie));
                        rd_reg(1'b0, v); chk("R8 read value", v, exp_w);
                        peek(1'b0, v); chk("R8 read clears", v, 16'h0020);
                        chk("R9 irq cleared", {15'd0, irq}, 16'd0);
                    end
                end
            end
        end

        // R4 start while busy is ignored
        wr_reg(1'b1, 16'h0118);
        start_cmd(1'b1, l); chk("R4 first launch", {15'd0, l}, 16'd1);
        start_cmd(1'b0, l); chk("R4 busy start", {15'd0, l}, 16'd0);
        peek(1'b0, v); chk("R4 no flag", v, 16'h0024);
        engine_done(1'b1);
        @(negedge clk);
        peek(1'b0, v); chk("R4 single completion", v, 16'h0029);

        // R8 busy bit not cleared by read
        rd_reg(1'b0, v);
        start_cmd(1'b0, l);
        rd_reg(1'b0, v);
        peek(1'b0, v); chk("R8 busy survives read", v, 16'h0024);

        // R10 read and completion in the same cycle
        repeat (1) @(negedge clk);
        eng_done = 1'b1; eng_ok = 1'b0; reg_sel = 1'b0; reg_rd = 1'b1;
        @(negedge clk); eng_done = 1'b0; reg_rd = 1'b0;
        peek(1'b0, v); chk("R10 event wins", v, 16'h002A);
        rd_reg(1'b0, v);

        // R11 accumulation over two completions
        start_cmd(1'b1, l); engine_done(1'b1);
        start_cmd(1'b1, l); engine_done(1'b0);
        peek(1'b0, v); chk("R11 both flags", v, 16'h002B);

        // R8 status write ignored
        wr_reg(1'b0, 16'hFFFF);
        peek(1'b0, v); chk("R8 status write ignored", v, 16'h002B);
        peek(1'b1, v); chk("R8 mode untouched", v, 16'h0118);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule